// File: doc/BRIEF.md
# CPU Reset and Interrupt Poll Unit

This block sits beside the sequencer of an 8-bit accumulator-style processor core. It supplies the register values the core starts from after a reset, and it decides at each instruction boundary whether the core should enter its interrupt sequence. Two kinds of reset exist. A hard reset (also the power-on reset) loads fixed values. A soft reset keeps the general registers, lowers the stack pointer by three and sets the interrupt-disable flag. Both kinds fetch the 16-bit start address from a two-byte vector through a synchronous memory read port with one cycle of latency. The block holds `ready` low until both bytes are in.

Interrupt polling follows a sampled pipeline. On every core cycle that is not stalled by DMA, the block evaluates a run condition: a pending NMI, or a non-zero IRQ request count while interrupt-disable is clear. The condition moves through a short shift chain. The decision at a boundary uses the condition that was sampled one cycle before the instruction's final cycle. While the core is stalled, the chain holds its contents. A hard reset empties the chain and a soft reset leaves it alone. The block also emits a one-cycle clear strobe, which the core uses to drop its NMI-pending flag and its IRQ count on any reset.

Top module: `cpu_rst_irq_poll`

## Requirements
- R1: While `rst` is high, `ready` and `mem_rd` are low. After `rst` falls, the block runs a hard-reset sequence by itself.
- R2: A request is accepted at a clock edge. After that edge, `mem_rd` is high for two cycles. `mem_addr` is `VEC_ADDR` in the first of these cycles and `VEC_ADDR+1` in the second. Read data arrives one cycle after its address. `ready` rises after the third edge, with `pc` = {high byte, low byte}.
- R3: After a hard reset is accepted, `a`, `x` and `y` are 0, `sp` is 0xFD, and `ps` is 0x24. In `ps`, bit 5 is the reserved bit and bit 2 is interrupt-disable.
- R4: After a soft reset is accepted, `a`, `x` and `y` equal `cur_a`, `cur_x` and `cur_y` as sampled at the accepting edge. `sp` equals `cur_sp` minus 3, modulo 256. `ps` equals `cur_ps` with bit 2 set.
- R5: `src_clr` is high for exactly the one cycle that follows each accepted request.
- R6: Requests are accepted only while `ready` is high (or for the automatic post-power-on sequence). A request made during a fetch has no effect. When both requests arrive in the same cycle, the hard reset wins.
- R7: At each edge where `tick` is high and `dma_stall` is low, the sampled condition is `nmi_pend | (irq_cnt != 0 & !idis)`.
- R8: `take` = `boundary & ready & S`. S is the condition sampled at the second most recent qualifying tick.
- R9: A tick with `dma_stall` high leaves both sampled conditions unchanged.
- R10: An accepted hard reset clears both sampled conditions, and this overrides a sample in the same cycle. A soft reset leaves them unchanged.
- R11: `take` is never high without `boundary`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | Core cycle strobe |
| boundary | input | 1 | Instruction boundary decision strobe |
| hard_req | input | 1 | Hard reset request |
| soft_req | input | 1 | Soft reset request |
| nmi_pend | input | 1 | NMI pending flag from core |
| irq_cnt | input | CW | Number of active IRQ sources |
| idis | input | 1 | Current interrupt-disable flag |
| dma_stall | input | 1 | Core stalled by DMA |
| cur_a | input | DW | Current accumulator |
| cur_x | input | DW | Current X index |
| cur_y | input | DW | Current Y index |
| cur_sp | input | DW | Current stack pointer |
| cur_ps | input | DW | Current status register |
| mem_addr | output | 2*DW | Vector read address |
| mem_rd | output | 1 | Vector read enable |
| mem_data | input | DW | Read data, one cycle after address |
| pc | output | 2*DW | Start program counter |
| sp | output | DW | Initial stack pointer |
| a | output | DW | Initial accumulator |
| x | output | DW | Initial X |
| y | output | DW | Initial Y |
| ps | output | DW | Initial status |
| ready | output | 1 | Vector fetched, pc valid |
| src_clr | output | 1 | Clear NMI flag and IRQ count |
| take | output | 1 | Enter interrupt sequence |

## Verification
A hard reset request and a qualifying sample tick can land on the same edge. The bench drives exactly that, with `nmi_pend` high, and then checks that a later boundary gives no `take`. This shows that the clear overrode the sample. A boundary strobe can also fall inside a vector fetch while a taken condition sits in the chain. The bench checks that `take` stays low there, and that the same condition still produces `take` once a soft reset has finished. The sampling pipeline itself is swept over every pairing of condition inputs and stall bits across two ticks. A bench model predicts each `take`.

// File: rtl/cpu_rpoll_pkg.sv
package cpu_rpoll_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LO   = 2'd1,
    FS_HI   = 2'd2,
    FS_CAP  = 2'd3
  } fetch_st_t;

  localparam int unsigned PS_RSVD_BIT = 5;
  localparam int unsigned PS_IDIS_BIT = 2;
  localparam int unsigned SP_HARD_VAL = 'hFD;
  localparam int unsigned SP_SOFT_DROP = 3;
  localparam int unsigned NGPR = 3;
endpackage

// File: rtl/rp_vec_fetch.sv
module rp_vec_fetch
  import cpu_rpoll_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 16,
  parameter int unsigned VEC = 'hFFFC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hard_req,
  input  logic          soft_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_data,
  output logic [AW-1:0] pc,
  output logic          ready,
  output logic          start,
  output logic          start_hard
);
  localparam logic [AW-1:0] VEC_LO = AW'(VEC);
  localparam logic [AW-1:0] VEC_HI = AW'(VEC + 1);

  fetch_st_t     st_q;
  logic          boot_q;
  logic          ready_q;
  logic          rd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] lo_q;
  logic [AW-1:0] pc_q;

  assign start      = (st_q == FS_IDLE) && (boot_q || ready_q) && (boot_q || hard_req || soft_req);
  assign start_hard = boot_q || hard_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= FS_IDLE;
      boot_q  <= 1'b1;
      ready_q <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      lo_q    <= '0;
      pc_q    <= '0;
    end else begin
      case (st_q)
        FS_IDLE: begin
          if (start) begin
            st_q    <= FS_LO;
            boot_q  <= 1'b0;
            ready_q <= 1'b0;
            rd_q    <= 1'b1;
            addr_q  <= VEC_LO;
          end
        end
        FS_LO: begin
          addr_q <= VEC_HI;
          st_q   <= FS_HI;
        end
        FS_HI: begin
          lo_q <= mem_data;
          rd_q <= 1'b0;
          st_q <= FS_CAP;
        end
        default: begin
          pc_q    <= AW'({mem_data, lo_q});
          ready_q <= 1'b1;
          st_q    <= FS_IDLE;
        end
      endcase
    end
  end

  assign mem_addr = addr_q;
  assign mem_rd   = rd_q;
  assign pc       = pc_q;
  assign ready    = ready_q;

  // R2: reads never overlap a valid pc
  a_r2_rd_busy: assert property (@(posedge clk) disable iff (rst) mem_rd |-> !ready);
  // R2: second read cycle addresses the high byte
  a_r2_hi_addr: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == VEC_HI));
  // R6: ready only drops after a request
  a_r6_ready_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(hard_req || soft_req));
endmodule

// File: rtl/rp_reg_init.sv
module rp_reg_init
  import cpu_rpoll_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     start_hard,
  input  logic [NGPR-1:0][DW-1:0]  cur_gpr,
  input  logic [DW-1:0]            cur_sp,
  input  logic [DW-1:0]            cur_ps,
  output logic [NGPR-1:0][DW-1:0]  gpr,
  output logic [DW-1:0]            sp,
  output logic [DW-1:0]            ps,
  output logic                     src_clr
);
  localparam logic [DW-1:0] SP_HARD = DW'(SP_HARD_VAL);
  localparam logic [DW-1:0] IDIS_M  = DW'(1) << PS_IDIS_BIT;
  localparam logic [DW-1:0] RSVD_M  = DW'(1) << PS_RSVD_BIT;
  localparam logic [DW-1:0] PS_HARD = IDIS_M | RSVD_M;
  localparam logic [DW-1:0] DROP    = DW'(SP_SOFT_DROP);

  logic [DW-1:0] sp_q;
  logic [DW-1:0] ps_q;
  logic          clr_q;

  for (genvar g = 0; g < NGPR; g++) begin : g_lane
    logic [DW-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst)
        lane_q <= '0;
      else if (start)
        lane_q <= start_hard ? '0 : cur_gpr[g];
    end
    assign gpr[g] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= SP_HARD;
      ps_q  <= PS_HARD;
      clr_q <= 1'b0;
    end else begin
      clr_q <= start;
      if (start) begin
        sp_q <= start_hard ? SP_HARD : (cur_sp - DROP);
        ps_q <= start_hard ? PS_HARD : (cur_ps | IDIS_M);
      end
    end
  end

  assign sp      = sp_q;
  assign ps      = ps_q;
  assign src_clr = clr_q;

  // R3: hard reset loads fixed stack and status
  a_r3_hard_vals: assert property (@(posedge clk) disable iff (rst)
    (start && start_hard) |=> (sp == SP_HARD && ps == PS_HARD && gpr == '0));
  // R4: soft reset always leaves interrupt-disable set
  a_r4_soft_idis: assert property (@(posedge clk) disable iff (rst)
    (start && !start_hard) |=> ps[PS_IDIS_BIT]);
endmodule

// File: rtl/rp_irq_poll.sv
module rp_irq_poll #(
  parameter int unsigned CW    = 4,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          dma_stall,
  input  logic          clr_run,
  input  logic          nmi_pend,
  input  logic [CW-1:0] irq_cnt,
  input  logic          idis,
  input  logic          boundary,
  input  logic          ready,
  output logic          take
);
  logic [DEPTH-1:0] stg_q;
  logic             cond;
  logic             adv;

  assign cond = nmi_pend || ((irq_cnt != '0) && !idis);
  assign adv  = tick && !dma_stall;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic nxt;
    if (i == 0) begin : g_head
      assign nxt = cond;
    end else begin : g_body
      assign nxt = stg_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst || clr_run)
        stg_q[i] <= 1'b0;
      else if (adv)
        stg_q[i] <= nxt;
    end
  end

  assign take = boundary && ready && stg_q[DEPTH-1];

  // R9: a stalled tick freezes the sampling chain
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (tick && dma_stall && !clr_run) |=> $stable(stg_q));
  // R10: hard reset empties the chain
  a_r10_hard_clear: assert property (@(posedge clk) disable iff (rst)
    clr_run |=> (stg_q == '0));
  // R11: take only at a boundary
  a_r11_take_bnd: assert property (@(posedge clk) disable iff (rst) take |-> boundary);
  // R8: take never during a vector fetch
  a_r8_take_ready: assert property (@(posedge clk) disable iff (rst) take |-> ready);
endmodule

// File: rtl/cpu_rst_irq_poll.sv
module cpu_rst_irq_poll
  import cpu_rpoll_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned CW       = 4,
  parameter int unsigned VEC_ADDR = 'hFFFC,
  parameter int unsigned POLL_LAG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              boundary,
  input  logic              hard_req,
  input  logic              soft_req,
  input  logic              nmi_pend,
  input  logic [CW-1:0]     irq_cnt,
  input  logic              idis,
  input  logic              dma_stall,
  input  logic [DW-1:0]     cur_a,
  input  logic [DW-1:0]     cur_x,
  input  logic [DW-1:0]     cur_y,
  input  logic [DW-1:0]     cur_sp,
  input  logic [DW-1:0]     cur_ps,
  output logic [2*DW-1:0]   mem_addr,
  output logic              mem_rd,
  input  logic [DW-1:0]     mem_data,
  output logic [2*DW-1:0]   pc,
  output logic [DW-1:0]     sp,
  output logic [DW-1:0]     a,
  output logic [DW-1:0]     x,
  output logic [DW-1:0]     y,
  output logic [DW-1:0]     ps,
  output logic              ready,
  output logic              src_clr,
  output logic              take
);
  localparam int unsigned AW = 2 * DW;

  logic                    start;
  logic                    start_hard;
  logic [NGPR-1:0][DW-1:0] cur_gpr;
  logic [NGPR-1:0][DW-1:0] gpr;

  assign cur_gpr = {cur_y, cur_x, cur_a};
  assign a = gpr[0];
  assign x = gpr[1];
  assign y = gpr[2];

  rp_vec_fetch #(.DW(DW), .AW(AW), .VEC(VEC_ADDR)) u_fetch (
    .clk(clk), .rst(rst), .hard_req(hard_req), .soft_req(soft_req),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_data(mem_data),
    .pc(pc), .ready(ready), .start(start), .start_hard(start_hard)
  );

  rp_reg_init #(.DW(DW)) u_init (
    .clk(clk), .rst(rst), .start(start), .start_hard(start_hard),
    .cur_gpr(cur_gpr), .cur_sp(cur_sp), .cur_ps(cur_ps),
    .gpr(gpr), .sp(sp), .ps(ps), .src_clr(src_clr)
  );

  rp_irq_poll #(.CW(CW), .DEPTH(POLL_LAG)) u_poll (
    .clk(clk), .rst(rst), .tick(tick), .dma_stall(dma_stall),
    .clr_run(start && start_hard), .nmi_pend(nmi_pend), .irq_cnt(irq_cnt),
    .idis(idis), .boundary(boundary), .ready(ready), .take(take)
  );

  // R5: clear strobe lasts a single cycle
  a_r5_clr_pulse: assert property (@(posedge clk) disable iff (rst) src_clr |=> !src_clr);
  // R5: clear strobe follows the drop of ready or the boot sequence
  a_r5_clr_busy: assert property (@(posedge clk) disable iff (rst) src_clr |-> !ready);
endmodule

// File: tb/tb_cpu_rst_irq_poll.sv
module tb_cpu_rst_irq_poll;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, boundary = 1'b0, hard_req = 1'b0, soft_req = 1'b0;
  logic nmi_pend = 1'b0, idis = 1'b0, dma_stall = 1'b0;
  logic [3:0] irq_cnt = '0;
  logic [7:0] cur_a = '0, cur_x = '0, cur_y = '0, cur_sp = '0, cur_ps = '0;
  logic [15:0] mem_addr, pc;
  logic mem_rd, ready, src_clr, take;
  logic [7:0] mem_data, sp, a, x, y, ps;
  logic [7:0] vec_lo = 8'h34, vec_hi = 8'h12;

  int checks = 0, fails = 0, cyc = 0;
  logic m_poll = 1'b0, m_hold = 1'b0;

  cpu_rst_irq_poll dut (
    .clk(clk), .rst(rst), .tick(tick), .boundary(boundary), .hard_req(hard_req),
    .soft_req(soft_req), .nmi_pend(nmi_pend), .irq_cnt(irq_cnt), .idis(idis),
    .dma_stall(dma_stall), .cur_a(cur_a), .cur_x(cur_x), .cur_y(cur_y),
    .cur_sp(cur_sp), .cur_ps(cur_ps), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_data(mem_data), .pc(pc), .sp(sp), .a(a), .x(x), .y(y), .ps(ps),
    .ready(ready), .src_clr(src_clr), .take(take)
  );

  always_ff @(posedge clk)
    if (mem_rd)
      mem_data <= (mem_addr == 16'hFFFC) ? vec_lo : (mem_addr == 16'hFFFD) ? vec_hi : 8'hEE;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic cond_of(input logic n, input logic [3:0] c, input logic d);
    return n | ((c != 0) & ~d);
  endfunction

  // one clock: model of the sampling chain, then back to the falling edge
  task automatic step();
    logic hclr;
    hclr = hard_req & ready;
    @(posedge clk);
    if (hclr) begin
      m_poll = 1'b0; m_hold = 1'b0;
    end else if (tick & ~dma_stall) begin
      m_hold = m_poll; m_poll = cond_of(nmi_pend, irq_cnt, idis);
    end
    @(negedge clk);
  endtask

  // request accepted at next edge; checks the fetch timing (R2, R5)
  task automatic run_req(input logic hr, input logic sr, input logic [7:0] lo, input logic [7:0] hi);
    vec_lo = lo; vec_hi = hi;
    hard_req = hr; soft_req = sr;
    step();
    hard_req = 0; soft_req = 0; tick = 0;
    chk(mem_rd == 1 && mem_addr == 16'hFFFC, "R2 lo addr", mem_addr, 16'hFFFC);
    chk(src_clr == 1, "R5 clr high", src_clr, 1);
    chk(ready == 0, "R2 ready low", ready, 0);
    step();
    chk(mem_rd == 1 && mem_addr == 16'hFFFD, "R2 hi addr", mem_addr, 16'hFFFD);
    chk(src_clr == 0, "R5 clr one cycle", src_clr, 0);
    step();
    chk(ready == 0 && mem_rd == 0, "R2 still busy", ready, 0);
    step();
    chk(ready == 1, "R2 ready", ready, 1);
    chk(pc == {hi, lo}, "R2 pc", pc, {hi, lo});
  endtask

  initial begin
    // R1: reset state
    step(); step();
    chk(ready == 0 && mem_rd == 0, "R1 in reset", {ready, mem_rd}, 0);
    rst = 0;
    step();
    chk(mem_rd == 1 && mem_addr == 16'hFFFC, "R1 auto fetch", mem_addr, 16'hFFFC);
    chk(src_clr == 1, "R1 R5 clr", src_clr, 1);
    step(); step(); step();
    chk(ready == 1 && pc == 16'h1234, "R1 boot pc", pc, 16'h1234);
    chk(a == 0 && x == 0 && y == 0 && sp == 8'hFD && ps == 8'h24, "R3 boot vals", {a, x, y, sp, ps}, 40'h000000FD24);

    // R3: hard reset ignores current registers
    cur_a = 8'h11; cur_x = 8'h22; cur_y = 8'h33; cur_sp = 8'h44; cur_ps = 8'hC3;
    run_req(1, 0, 8'h00, 8'hC0);
    chk(a == 0 && x == 0 && y == 0, "R3 gpr clear", {a, x, y}, 0);
    chk(sp == 8'hFD, "R3 sp", sp, 8'hFD);
    chk(ps == 8'h24, "R3 ps", ps, 8'h24);

    // R4: soft reset sweep including stack wrap
    for (int i = 0; i < 8; i++) begin
      logic [7:0] spv;
      spv = (i < 4) ? 8'(i) : 8'(8'hFC + i);
      cur_a = 8'(i * 37); cur_x = 8'(i * 11 + 5); cur_y = 8'(255 - i); cur_sp = spv;
      cur_ps = 8'(i * 29);
      run_req(0, 1, 8'(i), 8'(8'h80 + i));
      chk(a == 8'(i * 37) && x == 8'(i * 11 + 5) && y == 8'(255 - i), "R4 gpr kept", {a, x, y}, {8'(i * 37), 8'(i * 11 + 5), 8'(255 - i)});
      chk(sp == 8'(spv - 3), "R4 sp drop", sp, 8'(spv - 3));
      chk(ps == (8'(i * 29) | 8'h04), "R4 ps idis", ps, 8'(i * 29) | 8'h04);
    end

    // R6: both requests together, hard wins; requests during fetch ignored
    cur_sp = 8'h50; cur_a = 8'h99;
    vec_lo = 8'h78; vec_hi = 8'h56;
    hard_req = 1; soft_req = 1;
    step();
    hard_req = 0; soft_req = 1;
    step();
    soft_req = 0; hard_req = 1;
    step();
    hard_req = 0;
    step();
    chk(ready == 1 && sp == 8'hFD && a == 0, "R6 hard wins", sp, 8'hFD);
    step();
    chk(mem_rd == 0 && ready == 1, "R6 busy req ignored", mem_rd, 0);

    // R7 R8 R9 R11: sweep condition inputs and stall over two ticks
    for (int p = 0; p < 512; p++) begin
      logic [3:0] cv;
      cv = p[8] ? 4'hF : 4'h1;
      tick = 1; dma_stall = p[6];
      nmi_pend = p[0]; irq_cnt = p[1] ? cv : 4'h0; idis = p[2];
      step();
      dma_stall = p[7];
      nmi_pend = p[3]; irq_cnt = p[4] ? cv : 4'h0; idis = p[5];
      #1 chk(take == 0, "R11 no take off boundary", take, 0);
      step();
      tick = 0; dma_stall = 0; nmi_pend = 0; irq_cnt = 0; idis = 0;
      boundary = 1;
      #1 chk(take == m_hold, "R7 R8 R9 take", take, m_hold);
      step();
      boundary = 0;
    end

    // R8: no take while fetching; R10: soft keeps chain
    tick = 1; nmi_pend = 1; step(); step();
    tick = 0; nmi_pend = 0;
    soft_req = 1; step(); soft_req = 0;
    boundary = 1;
    #1 chk(take == 0, "R8 no take busy", take, 0);
    step(); boundary = 0; step(); step();
    boundary = 1;
    #1 chk(take == 1, "R10 soft keeps", take, 1);
    step(); boundary = 0;

    // R10: hard reset on same edge as a sampling tick
    tick = 1; nmi_pend = 1; hard_req = 1;
    step();
    tick = 0; nmi_pend = 0; hard_req = 0;
    step(); step(); step();
    boundary = 1;
    #1 chk(take == 0, "R10 hard clears", take, 0);
    step(); boundary = 0;
    tick = 1; nmi_pend = 1; step(); tick = 0; nmi_pend = 0;
    boundary = 1;
    #1 chk(take == 0, "R8 one tick lag", take, 0);
    step(); boundary = 0;
    tick = 1; irq_cnt = 4'h2; step(); tick = 0; irq_cnt = 0;
    boundary = 1;
    #1 chk(take == 1, "R8 two ticks", take, 1);
    step(); boundary = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule